// File: doc/BRIEF.md
# Register-Controlled Reset Pulse Generator

This block drives one open-drain general-purpose output from a small byte-wide register bank. In plain output mode the pin is either released or actively pulled low, as a single level bit selects. In reset mode the level bit is ignored. Writing the fire code to a 3-bit trigger field then pulls the pin low for a fixed time. After the release, the field keeps reading the fire code for a selectable hold time and then clears itself. Software can poll this field to see when the target is ready again.

Register writes are accepted only while an unlock flag supplied by the surrounding logic is high. Any accepted write to the main configuration register sends an abort strobe to a converter, followed one cycle later by a restart strobe. A self-clearing bit in the same register returns every register to its power-on value. All times come from a clock-frequency parameter and are counted in clock cycles.

Top module: `rstpulse_ctl`

## Requirements
- R1: After reset every register reads 0x00 at all four addresses, the pin is released (`gpo_pull_low_o` = 0) and all strobes are low.
- R2: While `unlock_i` is low a write changes no register and raises no strobe.
- R3: With the mode bit (address 1, bit 7) set and no sequence active, writing 111 to the trigger field (address 2, bits 2:0) pulls the pin low from the clock edge of the write for exactly PULSE_US·CLK_HZ/10^6 cycles.
- R4: The trigger field reads 111 for exactly the selected hold time after the release edge and then reads 000. The hold select is address 1, bits 2:0: 0 selects DEF_CLR_US (22.5 ms by default), and 1 through 7 select 100 µs, 500 µs, 1 ms, 5 ms, 10 ms, 50 ms and 100 ms.
- R5: A trigger value other than 111 is stored and reads back, but starts no pulse. Trigger writes made while a pulse or hold is active are ignored.
- R6: With the mode bit clear, the pin is pulled low exactly when the level bit (address 0, bit 6) is 1, and the trigger field has no effect on the pin. With the mode bit set, the level bit has no effect.
- R7: Unused bits read 0: address 0 bits 7 and 5:0, address 1 bits 6:3, address 2 bits 7:3, and all of address 3.
- R8: An accepted write to address 0 raises `abort_o` for the one cycle after the write edge, and `restart_o` for the cycle after that.
- R9: An accepted write to address 0 with bit 7 set returns all registers and any active sequence to the reset state at that edge, and raises `swrst_o` for one cycle.
- R10: Clearing the mode bit while a sequence is active ends it at that edge: the pin is released and the trigger field reads 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_i | input | 1 | Write permission flag from password logic |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| gpo_pull_low_o | output | 1 | 1 = open-drain pin driven low, 0 = released |
| abort_o | output | 1 | Conversion abort strobe |
| restart_o | output | 1 | Conversion restart strobe |
| swrst_o | output | 1 | Software reset strobe |

## Verification
Each fault shows up as a wrong pulse length or a wrong hold length. A counter loaded off by one shifts the release edge or the trigger clear by one cycle, and this is visible at the pin or at address 2 within one pulse-plus-hold period. A sequencer stuck outside idle shows at once: the next 111 write fails to pull the pin low. A missing cancel leaves the pin low after the mode bit is cleared, which is visible on the very next cycle. Broken unlock gating or broken strobe ordering is visible on a read or a strobe within one or two cycles of the write.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    localparam int          REG_AW    = 2;
    localparam int          REG_DW    = 8;
    localparam int          SEL_W     = 3;
    localparam int          SEL_N     = 1 << SEL_W;
    localparam logic [1:0]  A_CFG     = 2'd0;
    localparam logic [1:0]  A_MODE    = 2'd1;
    localparam logic [1:0]  A_TRIG    = 2'd2;
    localparam logic [2:0]  TRIG_FIRE = 3'b111;

    // hold time in microseconds for each select code
    function automatic longint clr_us(input int sel, input longint def_us);
        case (sel)
            0:       return def_us;
            1:       return 64'd100;
            2:       return 64'd500;
            3:       return 64'd1000;
            4:       return 64'd5000;
            5:       return 64'd10000;
            6:       return 64'd50000;
            default: return 64'd100000;
        endcase
    endfunction

    function automatic longint us_to_cyc(input longint us, input longint hz);
        longint c;
        c = (us * hz) / 64'd1000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

    function automatic longint max_cyc(input longint pulse_us, input longint def_us,
                                       input longint hz);
        longint m;
        m = us_to_cyc(pulse_us, hz);
        for (int s = 0; s < SEL_N; s++) begin
            if (us_to_cyc(clr_us(s, def_us), hz) > m) m = us_to_cyc(clr_us(s, def_us), hz);
        end
        return m;
    endfunction

endpackage

// File: rtl/rpg_timer.sv
module rpg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero_o = (st_q.cnt == '0);

    // R3: an expired counter stays expired until reloaded
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/rpg_seq.sv
module rpg_seq
    import rpg_pkg::*;
#(
    parameter int     CW       = 8,
    parameter longint CLK_HZ   = 64'd50000000,
    parameter longint PULSE_US = 64'd125,
    parameter longint DEF_US   = 64'd22500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill_i,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             busy_o,
    output logic             pulse_o,
    output logic             done_o
);
    localparam logic [CW-1:0] PULSE_LD = CW'(us_to_cyc(PULSE_US, CLK_HZ) - 1);

    typedef struct packed {
        phase_e phase;
    } seq_t;

    seq_t          st_d, st_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic [CW-1:0] clr_ld [SEL_N];

    for (genvar g = 0; g < SEL_N; g++) begin : g_clr_tab
        assign clr_ld[g] = CW'(us_to_cyc(clr_us(g, DEF_US), CLK_HZ) - 1);
    end

    rpg_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done_o   = 1'b0;
        if (kill_i) begin
            st_d.phase = PH_IDLE;
            tmr_load   = 1'b1;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (start_i) begin
                        st_d.phase = PH_PULSE;
                        tmr_load   = 1'b1;
                        tmr_val    = PULSE_LD;
                    end
                end
                PH_PULSE: begin
                    if (tmr_zero) begin
                        st_d.phase = PH_HOLD;
                        tmr_load   = 1'b1;
                        tmr_val    = clr_ld[sel_i];
                    end
                end
                PH_HOLD: begin
                    if (tmr_zero) begin
                        st_d.phase = PH_IDLE;
                        done_o     = 1'b1;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE};
        else        st_q <= st_d;
    end

    assign busy_o  = (st_q.phase != PH_IDLE);
    assign pulse_o = (st_q.phase == PH_PULSE);

    // R5: the register bank only starts a sequence when this one is idle
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (st_q.phase == PH_IDLE));

    // R10: no sequence survives outside reset mode
    p_busy_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |-> mode_i);

    // R4: the hold phase is entered only from the pulse phase
    p_hold_from_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_HOLD) && ($past(st_q.phase) != PH_HOLD))
            |-> ($past(st_q.phase) == PH_PULSE));

endmodule

// File: rtl/rpg_regs.sv
module rpg_regs
    import rpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    input  logic [REG_AW-1:0] rd_addr_i,
    output logic [REG_DW-1:0] rd_data_o,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic              kill_o,
    output logic              mode_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              level_o,
    output logic              abort_o,
    output logic              restart_o,
    output logic              swrst_o
);
    typedef struct packed {
        logic             level;
        logic             mode;
        logic [SEL_W-1:0] sel;
        logic [2:0]       trig;
        logic             abort;
        logic             restart;
        logic             swrst;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_ok;
    logic  swrst_hit;
    logic  mode_off_hit;

    assign wr_ok        = wr_en_i && unlock_i;
    assign swrst_hit    = wr_ok && (wr_addr_i == A_CFG) && wr_data_i[7];
    assign mode_off_hit = wr_ok && (wr_addr_i == A_MODE) && !wr_data_i[7] && busy_i;
    assign start_o      = wr_ok && (wr_addr_i == A_TRIG) && (wr_data_i[2:0] == TRIG_FIRE)
                          && st_q.mode && !busy_i;
    assign kill_o       = swrst_hit || mode_off_hit;

    always_comb begin
        st_d         = st_q;
        st_d.abort   = 1'b0;
        st_d.swrst   = 1'b0;
        st_d.restart = st_q.abort;
        if (done_i) st_d.trig = 3'b000;
        if (wr_ok) begin
            case (wr_addr_i)
                A_CFG: begin
                    st_d.level = wr_data_i[6];
                    st_d.abort = 1'b1;
                    if (wr_data_i[7]) begin
                        st_d.level = 1'b0;
                        st_d.mode  = 1'b0;
                        st_d.sel   = '0;
                        st_d.trig  = 3'b000;
                        st_d.swrst = 1'b1;
                    end
                end
                A_MODE: begin
                    st_d.mode = wr_data_i[7];
                    st_d.sel  = wr_data_i[SEL_W-1:0];
                    if (mode_off_hit) st_d.trig = 3'b000;
                end
                A_TRIG: begin
                    if (!busy_i) st_d.trig = wr_data_i[2:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr_i)
            A_CFG:   rd_data_o = {1'b0, st_q.level, 6'b000000};
            A_MODE:  rd_data_o = {st_q.mode, {(REG_DW-1-SEL_W){1'b0}}, st_q.sel};
            A_TRIG:  rd_data_o = {5'b00000, st_q.trig};
            default: rd_data_o = '0;
        endcase
    end

    assign mode_o    = st_q.mode;
    assign sel_o     = st_q.sel;
    assign level_o   = st_q.level;
    assign abort_o   = st_q.abort;
    assign restart_o = st_q.restart;
    assign swrst_o   = st_q.swrst;

    // R8: every abort is followed by a restart one cycle later
    p_restart_after_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |=> st_q.restart);

    // R2: nothing is written while locked
    p_locked_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_i |=> ($stable(st_q.level) && $stable(st_q.mode) && $stable(st_q.sel)
                       && !st_q.abort && !st_q.swrst));

    // R9: the reset strobe coincides with cleared registers
    p_swrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swrst |-> (!st_q.mode && !st_q.level && st_q.sel == '0 && st_q.trig == 3'b000));

    // R4: the end of a hold clears the trigger field
    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (st_q.trig == 3'b000));

endmodule

// File: rtl/rstpulse_ctl.sv
module rstpulse_ctl
    import rpg_pkg::*;
#(
    parameter longint CLK_HZ     = 64'd50000000,
    parameter longint PULSE_US   = 64'd125,
    parameter longint DEF_CLR_US = 64'd22500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unlock_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [1:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       gpo_pull_low_o,
    output logic       abort_o,
    output logic       restart_o,
    output logic       swrst_o
);
    localparam longint MAX_CYC = max_cyc(PULSE_US, DEF_CLR_US, CLK_HZ);
    localparam int     CW      = $clog2(MAX_CYC + 1);

    logic             busy;
    logic             pulse;
    logic             done;
    logic             start;
    logic             kill;
    logic             mode;
    logic [SEL_W-1:0] sel;
    logic             level;

    rpg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlock_i  (unlock_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .busy_i    (busy),
        .done_i    (done),
        .start_o   (start),
        .kill_o    (kill),
        .mode_o    (mode),
        .sel_o     (sel),
        .level_o   (level),
        .abort_o   (abort_o),
        .restart_o (restart_o),
        .swrst_o   (swrst_o)
    );

    rpg_seq #(
        .CW       (CW),
        .CLK_HZ   (CLK_HZ),
        .PULSE_US (PULSE_US),
        .DEF_US   (DEF_CLR_US)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill_i  (kill),
        .start_i (start),
        .mode_i  (mode),
        .sel_i   (sel),
        .busy_o  (busy),
        .pulse_o (pulse),
        .done_o  (done)
    );

    assign gpo_pull_low_o = mode ? pulse : level;

    // R6: in reset mode an idle sequencer leaves the pin released
    p_rstmode_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !busy) |-> !gpo_pull_low_o);

endmodule

// File: tb/rstpulse_ctl_bench.sv
`timescale 1ns/1ps
module rstpulse_ctl_bench;
    localparam longint CLK_HZ = 64'd80000;
    localparam int     P_CYC  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unlock = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pull, abort_s, restart_s, swrst_s;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done_flag = 1'b0;

    always #2.5 clk = ~clk;

    rstpulse_ctl #(.CLK_HZ(CLK_HZ), .PULSE_US(64'd125), .DEF_CLR_US(64'd22500)) u_rstpulse_ctl (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .gpo_pull_low_o(pull), .abort_o(abort_s),
        .restart_o(restart_s), .swrst_o(swrst_s)
    );

    function automatic int exp_hold(input int sel);
        longint us;
        case (sel)
            0: us = 22500; 1: us = 100; 2: us = 500; 3: us = 1000;
            4: us = 5000; 5: us = 10000; 6: us = 50000; default: us = 100000;
        endcase
        return int'(us * CLK_HZ / 1000000);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic unl = 1'b1);
        unlock = unl; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; unlock = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #0.1; v = int'(rd_data);
    endtask

    // start a sequence, measure pulse and hold lengths, optionally interfere
    task automatic run_seq(input int sel, input bit meddle);
        int cnt, h, v;
        wr(2'd1, 8'h80 | 8'(sel));
        wr(2'd2, 8'h07);
        cnt = 0;
        while (pull && cnt < 100) begin
            cnt++;
            if (meddle && cnt == 3) wr(2'd2, 8'h00);
            else if (meddle && cnt == 5) wr(2'd2, 8'h07);
            else @(negedge clk);
        end
        check("R3 pulse length", cnt, P_CYC);
        h = 0;
        rd(2'd2, v);
        while (v == 7 && h < 20000) begin
            h++;
            if (meddle && h == 2) wr(2'd2, 8'h03);
            else @(negedge clk);
            rd(2'd2, v);
        end
        check(meddle ? "R5 hold with ignored writes" : "R4 hold length", h, exp_hold(sel));
        check("R4 trigger cleared", v, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        bit exp_lvl;
        logic [7:0] m_cfg, m_mode, m_trig;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reset read", v, 0); end
        check("R1 pin", int'(pull), 0);
        check("R1 strobes", int'({abort_s, restart_s, swrst_s}), 0);

        // R2 locked writes
        wr(2'd0, 8'h40, 1'b0); wr(2'd1, 8'h87, 1'b0); wr(2'd2, 8'h07, 1'b0);
        rd(2'd0, v); check("R2 locked cfg", v, 0);
        rd(2'd1, v); check("R2 locked mode", v, 0);
        rd(2'd2, v); check("R2 locked trig", v, 0);
        check("R2 pin", int'(pull), 0);
        check("R2 no abort", int'(abort_s), 0);

        // R7 reserved bits
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R7 mode read", v, 8'h87);
        wr(2'd2, 8'hF8); rd(2'd2, v); check("R7 trig read", v, 0);
        check("R5 code 000 no pulse", int'(pull), 0);
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R7 addr3 read", v, 0);
        // R8 abort/restart and R6 level ignored in reset mode
        wr(2'd0, 8'h7F);
        check("R8 abort", int'(abort_s), 1);
        check("R8 restart early", int'(restart_s), 0);
        rd(2'd0, v); check("R7 cfg read", v, 8'h40);
        check("R6 level ignored in reset mode", int'(pull), 0);
        @(negedge clk);
        check("R8 restart", int'(restart_s), 1);
        check("R8 abort single", int'(abort_s), 0);
        @(negedge clk);
        check("R8 restart single", int'(restart_s), 0);
        wr(2'd0, 8'h00);
        @(negedge clk);

        // R5 stored non-fire codes
        wr(2'd1, 8'h81);
        wr(2'd2, 8'h03);
        rd(2'd2, v); check("R5 stored code", v, 3);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pull) begin check("R5 no pulse", 1, 0); break; end
        end
        check("R5 no pulse window", int'(pull), 0);

        // R3/R4 directed select codes
        run_seq(0, 1'b0);
        run_seq(1, 1'b0);
        run_seq(3, 1'b0);
        run_seq(2, 1'b1);
        for (int i = 0; i < 4; i++) run_seq(int'($urandom_range(1, 4)), 1'b0);

        // R10 cancel by clearing mode
        wr(2'd1, 8'h82); wr(2'd2, 8'h07);
        repeat (3) @(negedge clk);
        check("R10 pulsing", int'(pull), 1);
        wr(2'd1, 8'h02);
        check("R10 pin released", int'(pull), 0);
        rd(2'd2, v); check("R10 trig cleared", v, 0);
        wr(2'd1, 8'h81); wr(2'd2, 8'h07);
        check("R10 restart after cancel", int'(pull), 1);
        // R9 soft reset during pulse
        wr(2'd0, 8'h80);
        check("R9 strobe", int'(swrst_s), 1);
        check("R9 pin", int'(pull), 0);
        for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R9 regs cleared", v, 0); end
        @(negedge clk);
        check("R9 strobe single", int'(swrst_s), 0);

        // R6 random plain output mode
        exp_lvl = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 1) == 0) begin
                m_cfg = 8'($urandom) & 8'h7F;
                wr(2'd0, m_cfg);
                exp_lvl = m_cfg[6];
                check("R8 abort on cfg write", int'(abort_s), 1);
            end else begin
                wr(2'd2, 8'($urandom));
            end
            check("R6 level drives pin", int'(pull), int'(exp_lvl));
        end

        // R2 random locked writes
        wr(2'd1, 8'h85); wr(2'd2, 8'h02);
        rd(2'd0, v); m_cfg = 8'(v);
        rd(2'd1, v); m_mode = 8'(v);
        rd(2'd2, v); m_trig = 8'(v);
        for (int i = 0; i < 30; i++) begin
            wr(2'($urandom), 8'($urandom), 1'b0);
            check("R2 no strobe", int'({abort_s, swrst_s, pull}), 0);
        end
        rd(2'd0, v); check("R2 cfg held", v, int'(m_cfg));
        rd(2'd1, v); check("R2 mode held", v, int'(m_mode));
        rd(2'd2, v); check("R2 trig held", v, int'(m_trig));

        done_flag = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule